// File: doc/BRIEF.md
# Dual-Node Capacitor Discharge Timing Sequencer

This block sequences a resistive-sensor readout network built from two capacitors in series, with one sense node on each side of the upper capacitor and three resistor pins: one for the unknown sensor and two for calibration resistors of known value. After a start strobe it performs three charge/discharge pairs. In each charge it drives all five pins high. In each discharge it releases the two sense nodes and pulls exactly one resistor pin low. A single shared counter times each discharge from its first cycle. For each of the two sense nodes, the count is recorded at the first cycle in which that node reads low after synchronisation.

One run therefore leaves six cycle counts: sensor, calibration 1 and calibration 2, each seen at node A and at node B. A later arithmetic stage turns these counts into a resistance. A node that never reads low before the counter saturates is recorded at the saturated value and flagged, so a broken or open network cannot stall the sequence. Pin direction and level are presented as per-pin output-enable and output-value pairs, ready for a tri-state pad.

Top module: `dualNodeDischargeSeq`

## Requirements
- R1: After reset, and whenever no run is active, every pin has output-enable 0 and output value 0; `done` is 0. After reset all six time registers and all six timeout bits are 0.
- R2: In each charge phase both node pins and all three resistor pins have output-enable 1 and output value 1, for exactly `CHARGE_CYC` consecutive cycles.
- R3: In each discharge phase both node pins are released (enable 0). The selected resistor pin has enable 1 and value 0, and the other two resistor pins are released. The discharges run in this order: sensor (`resOe` bit 0), calibration 1 (bit 1), calibration 2 (bit 2). Released pins show value 0.
- R4: The counter reads 0 in the first discharge cycle. Suppose a raw sense input goes low at discharge cycle D and stays low. Its register then receives D+2, because the synchroniser has two stages.
- R5: Each node is captured on its own, into a dedicated register for that discharge. A discharge phase ends only after both nodes have been captured.
- R6: Only the first low sample of a node in a discharge is recorded. Later returns to high and drops back to low in the same phase leave the register unchanged.
- R7: If a node still reads high in the cycle where the counter sits at its maximum 2^`CNT_W`-1, the register receives that maximum and its timeout bit is set. A node that first reads low exactly at the maximum records the maximum with the timeout bit clear. The timeout bit order is: [0] sensor A, [1] sensor B, [2] cal1 A, [3] cal1 B, [4] cal2 A, [5] cal2 B.
- R8: `done` is high for exactly one cycle, the first idle cycle after the third discharge.
- R9: After a run, all time registers and timeout bits hold their values, whatever the sense inputs do, until the next accepted start. An accepted start clears all of them to 0.
- R10: A start strobe that arrives while a run is in progress is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begins a run when idle |
| senseA | input | 1 | Raw level at node A (asynchronous) |
| senseB | input | 1 | Raw level at node B (asynchronous) |
| nodeOe | output | 2 | Output enable for node A [0] and node B [1] pins |
| nodeOut | output | 2 | Output value for node pins |
| resOe | output | 3 | Output enable for sensor [0], cal1 [1], cal2 [2] pins |
| resOut | output | 3 | Output value for resistor pins |
| tSensA | output | CNT_W | Sensor discharge, node A count |
| tSensB | output | CNT_W | Sensor discharge, node B count |
| tCal1A | output | CNT_W | Calibration 1 discharge, node A count |
| tCal1B | output | CNT_W | Calibration 1 discharge, node B count |
| tCal2A | output | CNT_W | Calibration 2 discharge, node A count |
| tCal2B | output | CNT_W | Calibration 2 discharge, node B count |
| timeout | output | 6 | Per-register saturation flags |
| done | output | 1 | One-cycle end-of-run pulse |

## Verification
The hardest condition to reach is the edge of saturation. A node that first reads low exactly when the counter hits its maximum must record that value without a timeout, while a node one cycle later must be flagged. To reach both, the bench shrinks the counter width and then lowers the raw sense input at discharge cycles placed so that the synchronised low lands on the last count or one past it. It also places a bounce shortly after each node-A capture and a start pulse in the middle of a run. This shows that neither one disturbs the captured counts.

// File: rtl/dischSeqPkg.sv
package dischSeqPkg;
  localparam int NUM_PHASES = 3;
  localparam int NUM_NODES = 2;
  localparam int NUM_SLOTS = NUM_PHASES * NUM_NODES;

  typedef enum logic [1:0] {ST_IDLE, ST_CHARGE, ST_DISCH} seqState_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic       clrRegs;  // accepted start: clear results
    logic       cntClr;   // restart counter and capture flags
    logic       inDisch;  // capture window open
    logic [1:0] phase;    // 0 sensor, 1 cal1, 2 cal2
  } seqCtrl_t;
endpackage

// File: rtl/dischSeqCtrl.sv
module dischSeqCtrl
  import dischSeqPkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       start,
  input  logic       chargeEnd,
  input  logic       bothDone,
  output seqCtrl_t   ctrl,
  output logic [1:0] nodeOe,
  output logic [1:0] nodeOut,
  output logic [2:0] resOe,
  output logic [2:0] resOut,
  output logic       done
);
  localparam logic [1:0] LAST_PHASE = 2'(NUM_PHASES - 1);

  seqState_e state, stateNext;
  logic [1:0] phase, phaseNext;
  logic doneNext;

  always_comb begin
    stateNext = state;
    phaseNext = phase;
    doneNext = 1'b0;
    ctrl = '0;
    ctrl.phase = phase;
    ctrl.inDisch = (state == ST_DISCH);
    case (state)
      ST_IDLE: begin
        if (start) begin
          stateNext = ST_CHARGE;
          phaseNext = '0;
          ctrl.clrRegs = 1'b1;
          ctrl.cntClr = 1'b1;
        end
      end
      ST_CHARGE: begin
        if (chargeEnd) begin
          stateNext = ST_DISCH;
          ctrl.cntClr = 1'b1;
        end
      end
      ST_DISCH: begin
        if (bothDone) begin
          ctrl.cntClr = 1'b1;
          if (phase == LAST_PHASE) begin
            stateNext = ST_IDLE;
            doneNext = 1'b1;
          end else begin
            stateNext = ST_CHARGE;
            phaseNext = phase + 2'd1;
          end
        end
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_IDLE;
      phase <= '0;
      done <= 1'b0;
    end else begin
      state <= stateNext;
      phase <= phaseNext;
      done <= doneNext;
    end
  end

  // Pin configuration decoded from state
  always_comb begin
    nodeOe = '0;
    nodeOut = '0;
    resOe = '0;
    resOut = '0;
    if (state == ST_CHARGE) begin
      nodeOe = '1;
      nodeOut = '1;
      resOe = '1;
      resOut = '1;
    end else if (state == ST_DISCH) begin
      resOe = 3'(3'b001 << phase);
    end
  end
endmodule

// File: rtl/dischSeqDatapath.sv
module dischSeqDatapath
  import dischSeqPkg::*;
#(
  parameter int CNT_W = 14,
  parameter int CHARGE_CYC = 8192,
  parameter int SYNC_STAGES = 2
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  seqCtrl_t                      ctrl,
  input  logic [NUM_NODES-1:0]          senseRaw,
  output logic                          chargeEnd,
  output logic                          bothDone,
  output logic [NUM_SLOTS-1:0][CNT_W-1:0] slotVal,
  output logic [NUM_SLOTS-1:0]          slotTmo
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;
  localparam logic [CNT_W-1:0] CHARGE_LAST = CNT_W'(CHARGE_CYC - 1);

  logic [CNT_W-1:0] cnt;
  logic [NUM_NODES-1:0] syncLow, got, capEn;
  logic cntMax;
  logic [CNT_W-1:0] slotQ [NUM_SLOTS];
  logic [NUM_SLOTS-1:0] tmoQ;

  // Two-flop (parameterised) synchroniser per node, idles high
  for (genvar n = 0; n < NUM_NODES; n++) begin : g_sync
    logic [SYNC_STAGES-1:0] shReg;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) shReg <= '1;
      else shReg <= {shReg[SYNC_STAGES-2:0], senseRaw[n]};
    end
    assign syncLow[n] = ~shReg[SYNC_STAGES-1];
  end

  // Shared saturating counter
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) cnt <= '0;
    else if (ctrl.cntClr) cnt <= '0;
    else if (!cntMax) cnt <= cnt + 1'b1;
  end
  assign cntMax = (cnt == CNT_MAX);
  assign chargeEnd = (cnt == CHARGE_LAST);

  // First-low capture per node
  assign capEn = {NUM_NODES{ctrl.inDisch & cntMax}} & ~got
               | ({NUM_NODES{ctrl.inDisch}} & ~got & syncLow);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) got <= '0;
    else if (ctrl.cntClr) got <= '0;
    else got <= got | capEn;
  end
  assign bothDone = &got;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < NUM_SLOTS; i++) slotQ[i] <= '0;
      tmoQ <= '0;
    end else begin
      for (int i = 0; i < NUM_SLOTS; i++) begin
        if (ctrl.clrRegs) begin
          slotQ[i] <= '0;
          tmoQ[i] <= 1'b0;
        end else if (capEn[i % NUM_NODES] && ctrl.phase == 2'(i / NUM_NODES)) begin
          slotQ[i] <= cnt;
          tmoQ[i] <= ~syncLow[i % NUM_NODES];
        end
      end
    end
  end

  for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_out
    assign slotVal[i] = slotQ[i];
  end
  assign slotTmo = tmoQ;
endmodule

// File: rtl/dualNodeDischargeSeq.sv
module dualNodeDischargeSeq
  import dischSeqPkg::*;
#(
  parameter int CNT_W = 14,
  parameter int CHARGE_CYC = 8192
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic             senseA,
  input  logic             senseB,
  output logic [1:0]       nodeOe,
  output logic [1:0]       nodeOut,
  output logic [2:0]       resOe,
  output logic [2:0]       resOut,
  output logic [CNT_W-1:0] tSensA,
  output logic [CNT_W-1:0] tSensB,
  output logic [CNT_W-1:0] tCal1A,
  output logic [CNT_W-1:0] tCal1B,
  output logic [CNT_W-1:0] tCal2A,
  output logic [CNT_W-1:0] tCal2B,
  output logic [5:0]       timeout,
  output logic             done
);
  seqCtrl_t ctrl;
  logic chargeEnd, bothDone;
  logic [NUM_SLOTS-1:0][CNT_W-1:0] slotVal;

  dischSeqCtrl u_ctrl (
    .clk(clk), .rstN(rstN), .start(start),
    .chargeEnd(chargeEnd), .bothDone(bothDone), .ctrl(ctrl),
    .nodeOe(nodeOe), .nodeOut(nodeOut), .resOe(resOe), .resOut(resOut),
    .done(done)
  );

  dischSeqDatapath #(.CNT_W(CNT_W), .CHARGE_CYC(CHARGE_CYC)) u_dp (
    .clk(clk), .rstN(rstN), .ctrl(ctrl), .senseRaw({senseB, senseA}),
    .chargeEnd(chargeEnd), .bothDone(bothDone),
    .slotVal(slotVal), .slotTmo(timeout)
  );

  assign tSensA = slotVal[0];
  assign tSensB = slotVal[1];
  assign tCal1A = slotVal[2];
  assign tCal1B = slotVal[3];
  assign tCal2A = slotVal[4];
  assign tCal2B = slotVal[5];
endmodule

// File: rtl/dualNodeDischargeSeq_chk.sv
module dualNodeDischargeSeq_chk #(
  parameter int CNT_W = 14
) (
  input logic             clk,
  input logic             rstN,
  input logic             start,
  input logic [1:0]       nodeOe,
  input logic [2:0]       resOe,
  input logic [2:0]       resOut,
  input logic [CNT_W-1:0] tSensA,
  input logic [CNT_W-1:0] tSensB,
  input logic [CNT_W-1:0] tCal1A,
  input logic [CNT_W-1:0] tCal1B,
  input logic [CNT_W-1:0] tCal2A,
  input logic [CNT_W-1:0] tCal2B,
  input logic [5:0]       timeout,
  input logic             done
);
  localparam logic [CNT_W-1:0] MAXV = '1;

  // R3: never more than one resistor pin sinking
  a_r3_single_sink: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(resOe & ~resOut));

  // R7: a timeout flag implies a saturated register
  a_r7_tmo_sat: assert property (@(posedge clk) disable iff (!rstN)
    (timeout[0] |-> tSensA == MAXV) and (timeout[5] |-> tCal2B == MAXV));

  // R8: done lasts one cycle
  a_r8_done_pulse: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R8: done follows the calibration-2 discharge
  a_r8_done_after_cal2: assert property (@(posedge clk) disable iff (!rstN)
    done |-> $past(resOe) == 3'b100);

  // R9: results hold while idle without start
  a_r9_hold: assert property (@(posedge clk) disable iff (!rstN)
    (nodeOe == 2'b00 && resOe == 3'b000 && !start) |=>
      ($stable(tSensA) && $stable(tSensB) && $stable(tCal1A) &&
       $stable(tCal1B) && $stable(tCal2A) && $stable(tCal2B) && $stable(timeout)));
endmodule

bind dualNodeDischargeSeq dualNodeDischargeSeq_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rstN(rstN), .start(start), .nodeOe(nodeOe), .resOe(resOe),
  .resOut(resOut), .tSensA(tSensA), .tSensB(tSensB), .tCal1A(tCal1A),
  .tCal1B(tCal1B), .tCal2A(tCal2A), .tCal2B(tCal2B), .timeout(timeout),
  .done(done)
);

// File: tb/dualNodeDischargeSeq_test.sv
module dualNodeDischargeSeq_test;
  localparam int W = 6;
  localparam int CC = 16;
  localparam int MAXV = (1 << W) - 1;
  localparam int NEVER = 255;
  localparam int NV = 4;
  // per row: sensA, sensB, cal1A, cal1B, cal2A, cal2B discharge cycle of raw low
  localparam int VEC [NV][6] = '{
    '{5, 9, 20, 30, 40, 55},
    '{0, 1, 61, 62, 10, NEVER},
    '{NEVER, NEVER, 3, 3, 7, 50},
    '{30, 31, 1, 60, 62, 61}
  };

  logic clk = 0, rstN = 0, start = 0, senseA = 1, senseB = 1;
  logic [1:0] nodeOe, nodeOut;
  logic [2:0] resOe, resOut;
  logic [W-1:0] tSensA, tSensB, tCal1A, tCal1B, tCal2A, tCal2B;
  logic [5:0] timeout;
  logic done;
  int checks = 0, errors = 0;
  bit finished = 0;

  dualNodeDischargeSeq #(.CNT_W(W), .CHARGE_CYC(CC)) uut (
    .clk(clk), .rstN(rstN), .start(start), .senseA(senseA), .senseB(senseB),
    .nodeOe(nodeOe), .nodeOut(nodeOut), .resOe(resOe), .resOut(resOut),
    .tSensA(tSensA), .tSensB(tSensB), .tCal1A(tCal1A), .tCal1B(tCal1B),
    .tCal2A(tCal2A), .tCal2B(tCal2B), .timeout(timeout), .done(done)
  );

  always #2 clk = ~clk;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int regOf(input int i);
    case (i)
      0: return int'(tSensA);
      1: return int'(tSensB);
      2: return int'(tCal1A);
      3: return int'(tCal1B);
      4: return int'(tCal2A);
      default: return int'(tCal2B);
    endcase
  endfunction

  function automatic int expVal(input int d);
    if (d == NEVER || d + 2 > MAXV) return MAXV;
    return d + 2;
  endfunction

  function automatic int expTmo(input int d);
    return (d == NEVER || d + 2 > MAXV) ? 1 : 0;
  endfunction

  task automatic runVec(input int v, input bit busyStart);
    int chg, c, dA, dB;
    @(negedge clk) start = 1;
    @(negedge clk) start = 0;
    // R9: accepted start clears results
    for (int i = 0; i < 6; i++) chk("R9 clear on start", regOf(i), 0);
    chk("R9 clear timeouts", int'(timeout), 0);
    for (int p = 0; p < 3; p++) begin
      chg = 0;
      while (!(resOe == 3'(1 << p) && nodeOe == 2'b00)) begin
        if (nodeOe == 2'b11 && nodeOut == 2'b11 && resOe == 3'b111 && resOut == 3'b111)
          chg++;
        start = (busyStart && p == 1 && chg == 3);
        @(negedge clk);
      end
      start = 0;
      chk("R2 charge length", chg, CC);
      chk("R3 discharge levels", int'({resOut, nodeOut}), 0);
      dA = VEC[v][2*p];
      dB = VEC[v][2*p+1];
      c = 0;
      while (resOe == 3'(1 << p) && nodeOe == 2'b00) begin
        if (c == dA) senseA = 0;
        if (c == dA + 3) senseA = 1;  // bounce
        if (c == dA + 4) senseA = 0;
        if (c == dB) senseB = 0;
        c++;
        @(negedge clk);
      end
      senseA = 1;
      senseB = 1;
      if (p < 2) chk("R3 next phase recharges", int'(resOe), 7);
    end
    chk("R8 done high", int'(done), 1);
    chk("R1 idle pins", int'({nodeOe, resOe, nodeOut, resOut}), 0);
    @(negedge clk);
    chk("R8 done one cycle", int'(done), 0);
    for (int i = 0; i < 6; i++) begin
      chk("R4 R5 R6 captured count", regOf(i), expVal(VEC[v][i]));
      chk("R7 timeout bit", int'(timeout[i]), expTmo(VEC[v][i]));
    end
    if (busyStart) chk("R10 busy start ignored", int'(tSensA), expVal(VEC[v][0]));
  endtask

  initial begin
    #(4 * 150000);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int snap [6];
    int snapT;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1 reset pins", int'({nodeOe, nodeOut, resOe, resOut}), 0);
    chk("R1 reset done", int'(done), 0);
    for (int i = 0; i < 6; i++) chk("R1 reset regs", regOf(i), 0);
    chk("R1 reset timeouts", int'(timeout), 0);
    rstN = 1;
    @(negedge clk);

    for (int v = 0; v < NV; v++) runVec(v, v == 2);

    // R9: results hold after done despite sense activity
    for (int i = 0; i < 6; i++) snap[i] = regOf(i);
    snapT = int'(timeout);
    for (int k = 0; k < 12; k++) begin
      senseA = k[0];
      senseB = k[1];
      @(negedge clk);
    end
    senseA = 1;
    senseB = 1;
    repeat (3) @(negedge clk);
    for (int i = 0; i < 6; i++) chk("R9 hold after done", regOf(i), snap[i]);
    chk("R9 hold timeouts", int'(timeout), snapT);
    chk("R1 still idle", int'({nodeOe, resOe}), 0);

    // Back-to-back run after the hold test
    runVec(0, 1'b0);

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule